// File: doc/BRIEF.md
# Background Flash Streaming Engine

This block copies a linear run of 32-bit words from a serial flash port into a two-entry FIFO, where a DMA picks them up. Software loads a word-aligned start address and then writes a word count. Any nonzero count starts a stream. The engine issues one read request at a time, and only in cycles where the flash port carries no normal traffic. After each accepted request the address moves on by one word and the count goes down by one. The stream stops when the count reaches zero.

Writing zero to the count stops the stream at once. If a read is already in flight, its returning word is thrown away. The FIFO reports its level through two flags only, full and empty. Popping the FIFO returns the oldest word, or zero when the FIFO is empty.

Top module: `flash_stream_engine`

## Requirements
- R1: After reset the address reads 0, the count reads 0, the empty flag is 1 and the full flag is 0. The address register keeps only bits [31:2], so bits [1:0] of `cur_addr` always read as zero.
- R2: While a stream runs, the requests carry consecutive word addresses. The first request uses the loaded address, and each accepted request (`req_valid` and `req_ready` both high) moves the address up by 4.
- R3: The count is 22 bits wide and a nonzero write starts a stream. Each accepted request lowers the count by one. No request is raised while the count is zero, nor in a cycle in which either register is written.
- R4: No request is raised in a cycle with `port_busy` high. A stall caused by `port_busy` leaves the address and count unchanged, and the stream resumes where it stopped.
- R5: At most one read is outstanding at a time. No request is raised while the FIFO level plus the outstanding reads would reach two.
- R6: Writing zero to the count stops further requests. The response of a read that is still outstanding at that write is dropped, so it never enters the FIFO. A response arriving in the same cycle as that write is still kept.
- R7: The FIFO returns words in arrival order on `pop_data`, and `pop` removes the head entry. `fifo_full` is 1 when two words are held, and `fifo_empty` is 1 when none are held.
- R8: `pop` on an empty FIFO returns zero on `pop_data` and leaves the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr | input | 1 | Load the start address |
| addr_wdata | input | 32 | Start address, bits [1:0] ignored |
| cnt_wr | input | 1 | Write the word count |
| cnt_wdata | input | 22 | Word count; zero aborts |
| pop | input | 1 | Remove the FIFO head |
| pop_data | output | 32 | FIFO head, or zero when empty |
| fifo_full | output | 1 | FIFO holds two words |
| fifo_empty | output | 1 | FIFO holds no word |
| cur_addr | output | 32 | Address of the next word to read |
| cur_count | output | 22 | Words left to request |
| port_busy | input | 1 | Flash port is serving normal traffic |
| req_valid | output | 1 | Stream read request |
| req_addr | output | 32 | Address of the requested word |
| req_ready | input | 1 | Flash port accepts the request |
| rsp_valid | input | 1 | Read data returns |
| rsp_data | input | 32 | Returned word |

## Verification
The hardest case to reach is an abort that lands while a read is outstanding: the flash model must have accepted a request and still be holding its response. The bench fixes the response latency at three cycles, waits until a request has been accepted, and then writes zero to the count. It then checks that the late word never shows up on the FIFO. Random phases cover the rest: they mix `port_busy`, stalls on `req_ready`, varying latency, sparse pops and occasional mid-stream aborts. These phases keep the FIFO near full while a read is still in flight.

// File: rtl/flash_stream_engine.sv
module flash_stream_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_wdata,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          fifo_full,
  output logic          fifo_empty,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  input  logic          port_busy,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data
);
  localparam int DEPTH = 2;
  localparam int LW = $clog2(DEPTH + 1);

  logic [AW-1:2] addr_q;
  logic [CW-1:0] cnt_q;
  logic          outst_q, drop_q;
  logic [DW-1:0] slot0_q, slot1_q;
  logic [LW-1:0] level_q;

  logic take, push, pop_ok, room;

  assign room      = (level_q + LW'(outst_q)) < LW'(DEPTH);
  assign req_valid = (cnt_q != '0) && !port_busy && !outst_q && room && !cnt_wr && !addr_wr;
  assign take      = req_valid && req_ready;
  assign push      = rsp_valid && outst_q && !drop_q;
  assign pop_ok    = pop && (level_q != '0);

  assign cur_addr   = {addr_q, 2'b00};
  assign req_addr   = cur_addr;
  assign cur_count  = cnt_q;
  assign fifo_empty = (level_q == '0);
  assign fifo_full  = (level_q == LW'(DEPTH));
  assign pop_data   = fifo_empty ? '0 : slot0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (addr_wr)   addr_q <= addr_wdata[AW-1:2];
      else if (take) addr_q <= addr_q + 1'b1;
      if (cnt_wr)    cnt_q <= cnt_wdata;
      else if (take) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      drop_q  <= 1'b0;
    end else if (take) begin
      outst_q <= 1'b1;
      drop_q  <= 1'b0;
    end else if (rsp_valid && outst_q) begin
      outst_q <= 1'b0;
      drop_q  <= 1'b0;
    end else if (cnt_wr && cnt_wdata == '0 && outst_q) begin
      drop_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0_q <= '0;
      slot1_q <= '0;
      level_q <= '0;
    end else begin
      if (pop_ok) slot0_q <= slot1_q;
      if (push) begin
        if ((level_q - LW'(pop_ok)) == '0) slot0_q <= rsp_data;
        else                               slot1_q <= rsp_data;
      end
      level_q <= level_q + LW'(push) - LW'(pop_ok);
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cur_addr == $past(cur_addr) + 32'd4);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cur_count == $past(cur_count) - 1'b1);

  // R5
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_valid);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full || pop);

  // R6
  abort_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr && cnt_wdata == '0 && !addr_wr |=> !req_valid);

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty && pop && !rsp_valid |=> fifo_empty);

endmodule

// File: tb/flash_stream_engine_tb_top.sv
module flash_stream_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr = 1'b0, cnt_wr = 1'b0, pop = 1'b0;
  logic [31:0] addr_wdata = '0;
  logic [21:0] cnt_wdata = '0;
  logic [31:0] pop_data, cur_addr, req_addr;
  logic [21:0] cur_count;
  logic        fifo_full, fifo_empty, req_valid;
  logic        port_busy = 1'b0, req_ready = 1'b0, rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;

  always #10 clk = ~clk;

  flash_stream_engine dut_i (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .pop(pop), .pop_data(pop_data),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .cur_addr(cur_addr),
    .cur_count(cur_count), .port_busy(port_busy), .req_valid(req_valid),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data));

  int n_chk = 0, n_bad = 0;
  int busy_pct = 0, ready_pct = 100, lat_min = 0, lat_max = 0;
  logic [31:0] exp_addr = '0;
  int          exp_cnt = 0;
  bit          pend = 0, discard = 0;
  int          pend_lat = 0;
  logic [31:0] pend_data = '0;
  logic [31:0] q[$];

  function automatic logic [31:0] flash_word(logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit wa, logic [31:0] av, bit wc, logic [21:0] cv, bit want_pop);
    bit rsp_now, exp_req, took;
    @(negedge clk);
    addr_wr = wa; addr_wdata = av; cnt_wr = wc; cnt_wdata = cv; pop = want_pop;
    port_busy = ($urandom % 100) < busy_pct;
    req_ready = ($urandom % 100) < ready_pct;
    rsp_now   = pend && pend_lat == 0;
    rsp_valid = rsp_now;
    rsp_data  = rsp_now ? pend_data : $urandom;
    #2;
    check("R2 cur_addr", cur_addr, exp_addr);
    check("R3 cur_count", {10'd0, cur_count}, exp_cnt);
    check("R7 fifo_full", {31'd0, fifo_full}, {31'd0, q.size() == 2});
    check("R7 fifo_empty", {31'd0, fifo_empty}, {31'd0, q.size() == 0});
    exp_req = exp_cnt != 0 && !port_busy && !pend && (q.size() + int'(pend)) < 2 && !wa && !wc;
    if (port_busy)  check("R4 req while busy", {31'd0, req_valid}, 32'd0);
    else if (pend)  check("R5 req while outstanding", {31'd0, req_valid}, 32'd0);
    else            check("R3 req_valid", {31'd0, req_valid}, {31'd0, exp_req});
    if (req_valid) check("R2 req_addr", req_addr, exp_addr);
    if (want_pop) begin
      if (q.size() != 0) check("R7 pop_data", pop_data, q[0]);
      else               check("R8 empty pop", pop_data, 32'd0);
    end
    took = req_valid && req_ready;
    if (want_pop && q.size() != 0) void'(q.pop_front());
    if (rsp_now) begin
      if (!discard) q.push_back(pend_data);
      pend = 0; discard = 0;
    end else if (pend) begin
      if (wc && cv == 0) discard = 1;
      pend_lat--;
    end
    if (took) begin
      pend = 1;
      pend_lat = lat_min + int'($urandom % (lat_max - lat_min + 1));
      pend_data = flash_word(exp_addr);
      exp_addr += 4; exp_cnt--;
    end
    if (wa) exp_addr = {av[31:2], 2'b00};
    if (wc) exp_cnt = cv;
  endtask

  task automatic drain(int pop_pct);
    for (int i = 0; i < 4000 && (exp_cnt != 0 || pend || q.size() != 0); i++)
      step(0, 0, 0, 0, ($urandom % 100) < pop_pct);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lvl;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset addr", cur_addr, 0);
    check("R1 reset count", {10'd0, cur_count}, 0);
    check("R1 reset empty", {31'd0, fifo_empty}, 1);
    check("R1 reset full", {31'd0, fifo_full}, 0);
    rst_n = 1'b1;

    // R1: low address bits dropped
    step(1, 32'h1000_0003, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check("R1 low bits zero", cur_addr, 32'h1000_0000);

    // R2 R3: plain stream, pops every cycle
    step(0, 0, 1, 22'd5, 0);
    drain(100);
    check("R3 count ends at zero", {10'd0, cur_count}, 0);
    check("R2 final address", cur_addr, 32'h1000_0014);

    // R5 R7: no pops, FIFO fills and requests stop
    lat_max = 2;
    step(1, 32'h0000_0100, 1, 22'd6, 0);
    repeat (20) step(0, 0, 0, 0, 0);
    check("R7 full after fill", {31'd0, fifo_full}, 1);
    check("R5 count held while full", {10'd0, cur_count}, 4);
    drain(60);

    // R8: pop on empty
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    check("R8 stays empty", {31'd0, fifo_empty}, 1);

    // R4: busy port stalls without moving
    busy_pct = 100;
    step(1, 32'h0000_2000, 1, 22'd3, 0);
    repeat (6) step(0, 0, 0, 0, 0);
    check("R4 stalled address", cur_addr, 32'h0000_2000);
    check("R4 stalled count", {10'd0, cur_count}, 3);
    busy_pct = 0;
    drain(100);

    // R6: abort with a read in flight
    lat_min = 3; lat_max = 3;
    step(1, 32'h0000_3000, 1, 22'd8, 0);
    for (int i = 0; i < 20 && !pend; i++) step(0, 0, 0, 0, 0);
    lvl = q.size();
    step(0, 0, 1, 22'd0, 0);
    repeat (6) step(0, 0, 0, 0, 0);
    check("R6 in-flight word dropped", {31'd0, fifo_empty}, {31'd0, lvl == 0});
    check("R6 no outstanding left", {31'd0, pend}, 0);
    drain(100);

    // random phases
    lat_min = 0; lat_max = 3;
    for (int r = 0; r < 40; r++) begin
      busy_pct = $urandom % 60; ready_pct = 40 + $urandom % 61;
      step(1, $urandom, 1, 22'(1 + $urandom % 12), 0);
      for (int c = 0; c < 30; c++) begin
        if ($urandom % 40 == 0) step(0, 0, 1, 22'd0, $urandom % 2);
        else step(0, 0, 0, 0, ($urandom % 100) < 35);
      end
      busy_pct = 0; ready_pct = 100;
      drain(100);
    end
    finish_run();
  end
endmodule